// File: doc/BRIEF.md
# Block Cipher Round Key Schedule Generator

This unit expands a 128-, 192- or 256-bit cipher key into the complete list of 32-bit round key words used by a 128-bit block cipher with 10, 12 or 14 rounds. A single `start_i` pulse latches the key, the key-length select and the direction select. The unit then emits one schedule word per clock on `word_o`, with its position in the schedule on `widx_o` and a `wvalid_o` qualifier. `busy_o` covers the run, and `done_o` pulses once when the run has finished.

The substitution table is not stored. It is computed in logic as a multiplicative inverse in the 256-element binary field followed by the affine map. A sliding window of the last Nk words feeds the recurrence, so only as much state as the longest key is held. The caller picks the direction. When decryption is chosen, every round key except the first and the last leaves the block passed through the inverse column mix, so it can feed an equivalent-inverse datapath directly.

Top module: `keysched_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy_o`, `done_o` and `wvalid_o` are low.
- R2: A run emits exactly 4*(Nk+7) words, with `widx_o` going 0, 1, 2 … up to the last index with no gap. That is 44, 52 or 60 words for Nk = 4, 6 or 8.
- R3: `ksize_i` selects Nk: 2'b00 gives 4 words (128 bits), 2'b01 gives 6 (192 bits), and 2'b10 or 2'b11 gives 8 (256 bits). Words 0 to Nk-1 are the key itself. Word j is `key_i[255-32*j -: 32]`, so a shorter key sits in the upper bits of `key_i`.
- R4: For index i ≥ Nk that is not covered by R5 or R6, the word is W[i-Nk] XOR W[i-1]. For the 128-bit key 2b7e1516 28aed2a6 abf71588 09cf4f3c, word 43 is b6630ca6.
- R5: With Nk = 8 and i mod 8 = 4, the word is W[i-8] XOR SubWord(W[i-1]). There is no rotation and no round constant.
- R6: With i ≥ Nk and i mod Nk = 0, the word is W[i-Nk] XOR SubWord(RotWord(W[i-1])) XOR {rc, 24'h0}. RotWord moves the top byte to the bottom. rc is 01 on first use and is multiplied by x modulo 0x11B after each use (01, 02, 04, … 80, 1B, 36).
- R7: With `decrypt_i` latched high, words 4 to 4*Nr-1 are emitted after the inverse column mix, with the most significant byte as row 0. Words 0 to 3 and the last four words are emitted unchanged. The recurrence always uses the unmixed words.
- R8: `busy_o` rises the cycle after an accepted `start_i`. The first word follows one cycle later, and one word follows each cycle after that until the last.
- R9: `done_o` is high for exactly one cycle, the cycle after the last word. At that point `busy_o` is already low.
- R10: `start_i` while `busy_o` is high is ignored. Changes to `key_i`, `ksize_i` and `decrypt_i` during a run have no effect on the words emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run; sampled only while idle |
| key_i | input | 256 | Cipher key, first word in the top bits |
| ksize_i | input | 2 | Key length select (R3 encoding) |
| decrypt_i | input | 1 | 1 = emit inverse-mixed middle round keys |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last word |
| wvalid_o | output | 1 | `word_o` and `widx_o` carry a schedule word |
| widx_o | output | 6 | Index of the word in the schedule |
| word_o | output | 32 | Schedule word |

## Verification
The bench builds the unit with its default sizes: 32-bit words, an 8-word window and 4-word blocks. With these sizes all three key lengths are reachable, and so is the 60-word schedule of the longest key. That in turn exposes the extra substitution step at i mod 8 = 4 and the seventh round-constant step on that key. Runs in both directions, with all three lengths, compare every emitted word against a model built on log/antilog tables. The runs also include a restart attempt and input changes in the middle of a run, which show that the latched settings hold.

// File: rtl/ks_pkg.sv
package ks_pkg;

  typedef enum logic [1:0] {
    KS_K128 = 2'b00,
    KS_K192 = 2'b01,
    KS_K256 = 2'b10
  } ksize_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // a^254 equals the inverse for a != 0 and gives 0 for 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] res;
    pw  = a;
    res = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw  = gf_mul(pw, pw);
      res = gf_mul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] sub_affine(input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] rot;
    acc = b;
    rot = b;
    for (int n = 0; n < 4; n++) begin
      rot = {rot[6:0], rot[7]};
      acc = acc ^ rot;
    end
    return acc ^ 8'h63;
  endfunction

endpackage

// File: rtl/ks_subword.sv
module ks_subword #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] w_o
);
  import ks_pkg::*;
  localparam int NBYTE = WORD_W / 8;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign w_o[8*b +: 8] = sub_affine(gf_inv(w_i[8*b +: 8]));
  end
endmodule

// File: rtl/ks_invmix.sv
module ks_invmix #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] col_i,
  output logic [WORD_W-1:0] col_o
);
  import ks_pkg::*;
  localparam int NROW = WORD_W / 8;

  logic [7:0] row [NROW];

  for (genvar r = 0; r < NROW; r++) begin : g_split
    assign row[r] = col_i[WORD_W-1-8*r -: 8];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign col_o[WORD_W-1-8*r -: 8] = gf_mul(8'h0e, row[r])
                                    ^ gf_mul(8'h0b, row[(r+1)%NROW])
                                    ^ gf_mul(8'h0d, row[(r+2)%NROW])
                                    ^ gf_mul(8'h09, row[(r+3)%NROW]);
  end
endmodule

// File: rtl/keysched_top.sv
module keysched_top #(
  parameter int WORD_W    = 32,
  parameter int MAX_NK    = 8,
  parameter int BLK_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [WORD_W*MAX_NK-1:0] key_i,
  input  logic [1:0]            ksize_i,
  input  logic                  decrypt_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  wvalid_o,
  output logic [$clog2(BLK_WORDS*(MAX_NK+7))-1:0] widx_o,
  output logic [WORD_W-1:0]     word_o
);
  import ks_pkg::*;

  localparam int KEY_W     = WORD_W * MAX_NK;
  localparam int MAX_WORDS = BLK_WORDS * (MAX_NK + 7);
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int SEL_W     = $clog2(MAX_NK);
  localparam int ROUND_ADD = 6;

  logic [WORD_W-1:0] key_q [MAX_NK];
  logic [WORD_W-1:0] win_q [MAX_NK];
  logic [IDX_W-1:0]  nk_q, last_q, mixend_q, idx_q, kpos_q;
  logic              dec_q, lastw_q;
  logic [7:0]        rcon_q;

  logic [IDX_W-1:0]  nk_d;
  logic [SEL_W-1:0]  back_sel;
  logic [WORD_W-1:0] prev_w, back_w, sub_in, sub_out, raw_w, mix_w, out_w;
  logic              kp_zero, kp_half, in_key, use_mix;

  always_comb begin
    unique case (ksize_i)
      KS_K128: nk_d = IDX_W'(4);
      KS_K192: nk_d = IDX_W'(6);
      default: nk_d = IDX_W'(MAX_NK);
    endcase
  end

  assign back_sel = SEL_W'(nk_q - 1'b1);
  assign prev_w   = win_q[0];
  assign back_w   = win_q[back_sel];
  assign kp_zero  = (kpos_q == '0);
  assign kp_half  = (nk_q == IDX_W'(MAX_NK)) && (kpos_q == IDX_W'(MAX_NK / 2));
  assign in_key   = (idx_q < nk_q);
  assign sub_in   = kp_zero ? {prev_w[WORD_W-9:0], prev_w[WORD_W-1 -: 8]} : prev_w;

  ks_subword #(.WORD_W(WORD_W)) u_sub (.w_i(sub_in), .w_o(sub_out));

  always_comb begin
    if (in_key)       raw_w = key_q[idx_q[SEL_W-1:0]];
    else if (kp_zero) raw_w = back_w ^ sub_out ^ {rcon_q, {(WORD_W-8){1'b0}}};
    else if (kp_half) raw_w = back_w ^ sub_out;
    else              raw_w = back_w ^ prev_w;
  end

  ks_invmix #(.WORD_W(WORD_W)) u_mix (.col_i(raw_w), .col_o(mix_w));

  assign use_mix = dec_q && (idx_q >= IDX_W'(BLK_WORDS)) && (idx_q < mixend_q);
  assign out_w   = use_mix ? mix_w : raw_w;

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      wvalid_o <= 1'b0;
      lastw_q  <= 1'b0;
      done_o   <= 1'b0;
      idx_q    <= '0;
      kpos_q   <= '0;
      rcon_q   <= 8'h01;
    end else begin
      done_o   <= lastw_q;
      wvalid_o <= busy_o;
      lastw_q  <= busy_o && (idx_q == last_q);
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          idx_q  <= '0;
          kpos_q <= '0;
          rcon_q <= 8'h01;
        end
      end else begin
        idx_q  <= idx_q + 1'b1;
        kpos_q <= (kpos_q == nk_q - 1'b1) ? '0 : kpos_q + 1'b1;
        if (!in_key && kp_zero) rcon_q <= gf_x2(rcon_q);
        if (idx_q == last_q) busy_o <= 1'b0;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (!busy_o && start_i) begin
      nk_q     <= nk_d;
      dec_q    <= decrypt_i;
      last_q   <= IDX_W'(BLK_WORDS) * (nk_d + IDX_W'(ROUND_ADD + 1)) - 1'b1;
      mixend_q <= IDX_W'(BLK_WORDS) * (nk_d + IDX_W'(ROUND_ADD));
      for (int j = 0; j < MAX_NK; j++) key_q[j] <= key_i[KEY_W-1-WORD_W*j -: WORD_W];
    end
    if (busy_o) begin
      for (int j = MAX_NK - 1; j > 0; j--) win_q[j] <= win_q[j-1];
      win_q[0] <= raw_w;
      word_o   <= out_w;
      widx_o   <= idx_q;
    end
  end
endmodule

// File: rtl/keysched_chk.sv
module keysched_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             wvalid_o,
  input logic [IDX_W-1:0] widx_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !wvalid_o));

  a_r2_index_step: assert property (@(posedge clk) disable iff (rst)
    (wvalid_o && $past(wvalid_o)) |-> (widx_o == $past(widx_o) + IDX_W'(1)));

  a_r8_first_index: assert property (@(posedge clk) disable iff (rst)
    $rose(wvalid_o) |-> (widx_o == '0));

  a_r8_word_needs_busy: assert property (@(posedge clk) disable iff (rst)
    wvalid_o |-> $past(busy_o));

  a_r8_busy_ends_with_word: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> wvalid_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(wvalid_o) && !wvalid_o && !busy_o));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_o && wvalid_o && start_i) |=> (wvalid_o && widx_o != '0));
endmodule

bind keysched_top keysched_chk chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .wvalid_o(wvalid_o), .widx_o(widx_o)
);

// File: tb/keysched_top_tb_top.sv
module keysched_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [1:0]   ksize_i = 2'b00;
  logic         decrypt_i = 1'b0;
  logic         busy_o, done_o, wvalid_o;
  logic [5:0]   widx_o;
  logic [31:0]  word_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] q_word [$];
  int          q_idx  [$];
  string       q_tag  [$];
  logic [31:0] last_seen;

  logic [7:0] alog_t [256];
  int         log_t  [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  keysched_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .ksize_i(ksize_i),
    .decrypt_i(decrypt_i), .busy_o(busy_o), .done_o(done_o), .wvalid_o(wvalid_o),
    .widx_o(widx_o), .word_o(word_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference arithmetic through log / antilog tables
  function automatic logic [7:0] m_dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return alog_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] v, r;
    v = (x == 0) ? 8'h00 : alog_t[(255 - log_t[x]) % 255];
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ 8'h63 >> i & 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_sub(input logic [31:0] w);
    return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] m_imix(input logic [31:0] w);
    logic [7:0] a [4];
    logic [31:0] r;
    for (int k = 0; k < 4; k++) a[k] = w[31-8*k -: 8];
    r[31:24] = m_mul(a[0],8'h0e) ^ m_mul(a[1],8'h0b) ^ m_mul(a[2],8'h0d) ^ m_mul(a[3],8'h09);
    r[23:16] = m_mul(a[0],8'h09) ^ m_mul(a[1],8'h0e) ^ m_mul(a[2],8'h0b) ^ m_mul(a[3],8'h0d);
    r[15:8]  = m_mul(a[0],8'h0d) ^ m_mul(a[1],8'h09) ^ m_mul(a[2],8'h0e) ^ m_mul(a[3],8'h0b);
    r[7:0]   = m_mul(a[0],8'h0b) ^ m_mul(a[1],8'h0d) ^ m_mul(a[2],8'h09) ^ m_mul(a[3],8'h0e);
    return r;
  endfunction

  // driver: builds expected schedule, pushes it, then runs the handshake
  task automatic run_case(input logic [255:0] key, input logic [1:0] ks, input bit dec, input bit poke);
    int nk, nr, tot, n;
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    nk  = (ks == 2'b00) ? 4 : (ks == 2'b01) ? 6 : 8;
    nr  = nk + 6;
    tot = 4 * (nr + 1);
    rc  = 8'h01;
    for (int i = 0; i < tot; i++) begin
      string tag;
      if (i < nk) begin
        w[i] = key[255-32*i -: 32];
        tag = "R3";
      end else begin
        t = w[i-1];
        tag = "R4";
        if (i % nk == 0) begin
          t = m_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = m_dbl(rc);
          tag = "R6";
        end else if (nk == 8 && i % 8 == 4) begin
          t = m_sub(t);
          tag = "R5";
        end
        w[i] = w[i-nk] ^ t;
      end
      if (dec && i >= 4 && i < 4*nr) begin
        q_word.push_back(m_imix(w[i]));
        q_tag.push_back("R7");
      end else begin
        q_word.push_back(w[i]);
        q_tag.push_back(tag);
      end
      q_idx.push_back(i);
    end
    @(negedge clk);
    key_i = key; ksize_i = ks; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", 32'(busy_o), 32'd1);
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
      if (poke && n == 10) begin
        start_i = 1'b1; key_i = ~key; ksize_i = ks ^ 2'b01; decrypt_i = ~dec;
      end
      if (poke && n == 11) start_i = 1'b0;
    end
    check(n == tot + 2, poke ? "R10 done timing after restart attempt" : "R9 done timing",
          32'(n), 32'(tot + 2));
    check(busy_o == 1'b0, "R9 busy low at done", 32'(busy_o), 32'd0);
    check(q_word.size() == 0, "R2 all words emitted", 32'(q_word.size()), 32'd0);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 32'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && wvalid_o) begin
      if (q_word.size() == 0) begin
        check(1'b0, "R2 unexpected word", word_o, 32'hx);
      end else begin
        logic [31:0] ew;
        int ei;
        string et;
        ew = q_word.pop_front();
        ei = q_idx.pop_front();
        et = q_tag.pop_front();
        check(widx_o == 6'(ei), "R2 word index", 32'(widx_o), 32'(ei));
        check(word_o == ew, et, word_o, ew);
      end
      last_seen = word_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    v = 8'h01;
    for (int k = 0; k < 255; k++) begin
      alog_t[k] = v;
      log_t[v]  = k;
      v = v ^ m_dbl(v);
    end
    alog_t[255] = 8'h01;
    log_t[0] = 0;

    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !wvalid_o, "R1 outputs in reset",
          {29'd0, busy_o, done_o, wvalid_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !wvalid_o, "R1 idle after reset",
          {29'd0, busy_o, done_o, wvalid_o}, 32'd0);

    run_case({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 1'b0, 1'b0);
    check(last_seen == 32'hb6630ca6, "R4 known last word 128", last_seen, 32'hb6630ca6);
    run_case({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 2'b00, 1'b1, 1'b0);
    run_case({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 2'b01, 1'b0, 1'b0);
    run_case({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 2'b01, 1'b1, 1'b0);
    run_case(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
             2'b10, 1'b0, 1'b0);
    run_case(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
             2'b11, 1'b1, 1'b1);
    run_case(256'hffffffff00000000ffffffff00000000a5a5a5a55a5a5a5a0123456789abcdef,
             2'b10, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule